// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a NOR-style flash memory model. It watches bus write strobes, each carrying a 22-bit address and a 16-bit data word, and recognises the unlock-prefixed write sequences that request a word program, a block erase or a chip erase. When a sequence completes, it emits a one-cycle start pulse to a separate program/erase engine. The address and data of the final cycle are latched on the same edge. The block erase index is derived from the upper address bits.

The decoder also tracks which read mode the memory is in: normal array read, or the signature (identifier) mode. In signature mode, a small registered multiplexer returns the manufacturer code or the device code, selected by the two low read-address bits. Writes are accepted only while the programming-voltage-present flag is high and the engine is not busy.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the block is in array read mode with no sequence in progress: all start pulses are 0, `in_sig_mode` is 0 and `id_word` is 0000h.
- R2: Only address bits 10..0 and data bits 7..0 take part in recognising command cycles. The remaining address and data bits may hold any value.
- R3: Every multi-cycle command opens with data AAh at key address 555h, followed by data 55h at key address 2AAh.
- R4: A write whose low data byte is F0h returns the block to array read mode and clears the sequence position. This holds at any address and in any position of a sequence, except the data cycle of a word program. This also covers the unlock pair followed by F0h.
- R5: The unlock pair followed by 90h at 555h sets `in_sig_mode` one clock after that write. The block stays in signature mode until an F0h reset. While in signature mode, program and erase sequences start nothing.
- R6: `id_word` is registered one clock from `rd_addr` and the mode. In signature mode, `rd_addr`=00 gives 0020h, `rd_addr`=01 gives the device code (parameter, default 88A8h), and other values give 0000h. In array read mode it is 0000h.
- R7: The unlock pair, then A0h at 555h, then any write, pulses `prog_start` for one clock after that fourth write. `cmd_addr` and `cmd_data` hold that write's full address and data.
- R8: The unlock pair, 80h at 555h, the unlock pair again, then 30h at any address pulses `blk_erase_start` for one clock. `blk_idx` equals address bits 21..16 of the final write.
- R9: The same five-write prefix as R8, followed by 10h at 555h, pulses `chip_erase_start` for one clock.
- R10: A write that does not fit the expected next cycle clears the sequence position, and no start pulse follows. Array read mode stays array read mode, and signature mode stays signature mode.
- R11: A strobe while `hv_ok` is 0 is ignored: the sequence position, the mode and the outputs are unchanged.
- R12: A strobe while `busy` is 1 is ignored, including F0h.
- R13: At most one start pulse is high in any clock, and no pulse lasts longer than one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 22 | Write address |
| wr_data | input | 16 | Write data |
| hv_ok | input | 1 | Programming voltage present; writes accepted only when 1 |
| busy | input | 1 | Program/erase engine busy; writes ignored when 1 |
| rd_addr | input | 2 | Low read-address bits selecting the identifier word |
| prog_start | output | 1 | Word program start pulse |
| blk_erase_start | output | 1 | Block erase start pulse |
| chip_erase_start | output | 1 | Chip erase start pulse |
| cmd_addr | output | 22 | Address latched with the last start pulse |
| cmd_data | output | 16 | Data latched with the last start pulse |
| blk_idx | output | 6 | Block index, bits 21..16 of `cmd_addr` |
| in_sig_mode | output | 1 | 1 while in signature read mode |
| id_word | output | 16 | Identifier word for the current read address |

## Verification
Directed sequences drive each command with junk in the upper address and data bits, so that the compare width is tested. Each sequence is also broken at chosen cycles, to separate a correct restart from a stale sequence position. Gated writes are placed in the middle of a sequence and then followed by the sequence's remaining cycles: a start pulse that still arrives shows that the position was held rather than cleared. Signature mode is entered and then probed with program attempts, with gated resets, and with the three identifier selections. A long stream of random writes is biased toward the correct next cycle and mixed with junk; it is compared after every write against a bench model of the sequences.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM, S_ER1, S_ER2, S_ER3
  } seq_e;

  localparam int KEY_AW = 11;
  localparam int KEY_DW = 8;

  localparam logic [KEY_AW-1:0] K_ADDR_A = 11'h555;
  localparam logic [KEY_AW-1:0] K_ADDR_B = 11'h2AA;

  localparam logic [KEY_DW-1:0] K_UNLK_A = 8'hAA;
  localparam logic [KEY_DW-1:0] K_UNLK_B = 8'h55;
  localparam logic [KEY_DW-1:0] K_RESET  = 8'hF0;
  localparam logic [KEY_DW-1:0] K_SIG    = 8'h90;
  localparam logic [KEY_DW-1:0] K_PROG   = 8'hA0;
  localparam logic [KEY_DW-1:0] K_ERASE  = 8'h80;
  localparam logic [KEY_DW-1:0] K_BLK    = 8'h30;
  localparam logic [KEY_DW-1:0] K_CHIP   = 8'h10;
endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              sig_mode,
  output logic              prog_start,
  output logic              blk_start,
  output logic              chip_start,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              ev_sig,
  output logic              ev_reset
);
  seq_e st, nxt;
  logic go_p, go_b, go_c;
  logic [KEY_AW-1:0] ka;
  logic [KEY_DW-1:0] kd;
  logic at_a, at_b;

  assign ka   = addr[KEY_AW-1:0];
  assign kd   = data[KEY_DW-1:0];
  assign at_a = (ka == K_ADDR_A);
  assign at_b = (ka == K_ADDR_B);

  always_comb begin
    nxt      = st;
    go_p     = 1'b0;
    go_b     = 1'b0;
    go_c     = 1'b0;
    ev_sig   = 1'b0;
    ev_reset = 1'b0;
    if (acc) begin
      nxt = S_IDLE;
      if (st == S_PGM) begin
        go_p = 1'b1;
      end else if (kd == K_RESET) begin
        ev_reset = 1'b1;
      end else begin
        unique case (st)
          S_IDLE: if (at_a && kd == K_UNLK_A) nxt = S_UNL1;
          S_UNL1: if (at_b && kd == K_UNLK_B) nxt = S_UNL2;
          S_UNL2: begin
            if (at_a && kd == K_SIG)                     ev_sig = 1'b1;
            else if (at_a && kd == K_PROG  && !sig_mode) nxt = S_PGM;
            else if (at_a && kd == K_ERASE && !sig_mode) nxt = S_ER1;
          end
          S_ER1: if (at_a && kd == K_UNLK_A) nxt = S_ER2;
          S_ER2: if (at_b && kd == K_UNLK_B) nxt = S_ER3;
          S_ER3: begin
            if (kd == K_BLK)               go_b = 1'b1;
            else if (at_a && kd == K_CHIP) go_c = 1'b1;
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      prog_start <= 1'b0;
      blk_start  <= 1'b0;
      chip_start <= 1'b0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
    end else begin
      st         <= nxt;
      prog_start <= go_p;
      blk_start  <= go_b;
      chip_start <= go_c;
      if (go_p || go_b || go_c) begin
        cmd_addr <= addr;
        cmd_data <= data;
      end
    end
  end
endmodule

// File: rtl/fcd_mode_reg.sv
module fcd_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_sig,
  input  logic clr_sig,
  output logic sig_mode
);
  always_ff @(posedge clk) begin
    if (rst)          sig_mode <= 1'b0;
    else if (clr_sig) sig_mode <= 1'b0;
    else if (set_sig) sig_mode <= 1'b1;
  end
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux #(
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h88A8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_mode,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] id_word
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    unique case (sel)
      2'b00:   pick = MFR_CODE;
      2'b01:   pick = DEV_CODE;
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) id_word <= '0;
    else     id_word <= sig_mode ? pick : '0;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int              ADDR_W   = 22,
  parameter int              DATA_W   = 16,
  parameter int              BLK_W    = 6,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h88A8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hv_ok,
  input  logic              busy,
  input  logic [1:0]        rd_addr,
  output logic              prog_start,
  output logic              blk_erase_start,
  output logic              chip_erase_start,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              in_sig_mode,
  output logic [DATA_W-1:0] id_word
);
  logic acc, ev_sig, ev_reset;

  assign acc     = wr_stb && hv_ok && !busy;
  assign blk_idx = cmd_addr[ADDR_W-1 -: BLK_W];

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .addr       (wr_addr),
    .data       (wr_data),
    .sig_mode   (in_sig_mode),
    .prog_start (prog_start),
    .blk_start  (blk_erase_start),
    .chip_start (chip_erase_start),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .ev_sig     (ev_sig),
    .ev_reset   (ev_reset)
  );

  fcd_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .set_sig  (ev_sig),
    .clr_sig  (ev_reset),
    .sig_mode (in_sig_mode)
  );

  fcd_id_mux #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk      (clk),
    .rst      (rst),
    .sig_mode (in_sig_mode),
    .sel      (rd_addr),
    .id_word  (id_word)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [7:0]        wr_key,
  input logic              hv_ok,
  input logic              busy,
  input logic              prog_start,
  input logic              blk_erase_start,
  input logic              chip_erase_start,
  input logic              in_sig_mode,
  input logic [DATA_W-1:0] id_word
);
  logic any_start;
  assign any_start = prog_start || blk_erase_start || chip_erase_start;

  a_r13_one_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start, blk_erase_start, chip_erase_start}));

  a_r13_one_cycle: assert property (@(posedge clk) disable iff (rst)
    any_start |=> !any_start);

  a_r11_no_hv_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !hv_ok) |=> (!any_start && $stable(in_sig_mode)));

  a_r12_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && busy) |=> (!any_start && $stable(in_sig_mode)));

  a_r5_sig_blocks_start: assert property (@(posedge clk) disable iff (rst)
    in_sig_mode |=> !any_start);

  a_r5_sig_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sig_mode) |-> $past(wr_stb && hv_ok && !busy && wr_key == 8'h90));

  a_r6_read_mode_id: assert property (@(posedge clk) disable iff (rst)
    !in_sig_mode |=> (id_word == '0));

  a_r7_start_from_write: assert property (@(posedge clk) disable iff (rst)
    any_start |-> $past(wr_stb && hv_ok && !busy));
endmodule

bind flash_cmd_decoder fcd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .wr_stb           (wr_stb),
  .wr_key           (wr_data[7:0]),
  .hv_ok            (hv_ok),
  .busy             (busy),
  .prog_start       (prog_start),
  .blk_erase_start  (blk_erase_start),
  .chip_erase_start (chip_erase_start),
  .in_sig_mode      (in_sig_mode),
  .id_word          (id_word)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DEV = 16'h88A8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        hv_ok = 1'b1;
  logic        busy = 1'b0;
  logic [1:0]  rd_addr = 2'b00;
  logic        prog_start, blk_erase_start, chip_erase_start, in_sig_mode;
  logic [21:0] cmd_addr;
  logic [15:0] cmd_data, id_word;
  logic [5:0]  blk_idx;

  int n_chk = 0;
  int n_bad = 0;
  int m_st = 0;
  bit m_sig = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .hv_ok(hv_ok), .busy(busy), .rd_addr(rd_addr),
    .prog_start(prog_start), .blk_erase_start(blk_erase_start),
    .chip_erase_start(chip_erase_start), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .blk_idx(blk_idx), .in_sig_mode(in_sig_mode), .id_word(id_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected behaviour of one accepted write, from the requirements.
  task automatic model_step(input logic [21:0] a, input logic [15:0] d,
                            output bit ep, output bit eb, output bit ec);
    logic [10:0] k;
    logic [7:0]  c;
    k = a[10:0];
    c = d[7:0];
    ep = 0; eb = 0; ec = 0;
    if (m_st == 3) begin
      ep = 1; m_st = 0;
    end else if (c == 8'hF0) begin
      m_sig = 0; m_st = 0;
    end else begin
      case (m_st)
        0: m_st = (k == 11'h555 && c == 8'hAA) ? 1 : 0;
        1: m_st = (k == 11'h2AA && c == 8'h55) ? 2 : 0;
        2: begin
          m_st = 0;
          if (k == 11'h555) begin
            if (c == 8'h90) m_sig = 1;
            else if (c == 8'hA0 && !m_sig) m_st = 3;
            else if (c == 8'h80 && !m_sig) m_st = 4;
          end
        end
        4: m_st = (k == 11'h555 && c == 8'hAA) ? 5 : 0;
        5: m_st = (k == 11'h2AA && c == 8'h55) ? 6 : 0;
        6: begin
          m_st = 0;
          if (c == 8'h30) eb = 1;
          else if (c == 8'h10 && k == 11'h555) ec = 1;
        end
        default: m_st = 0;
      endcase
    end
  endtask

  // One write strobe; outputs checked in the clock after the capturing edge.
  task automatic wr(input logic [21:0] a, input logic [15:0] d, input bit hv = 1, input bit bz = 0);
    bit ep, eb, ec;
    ep = 0; eb = 0; ec = 0;
    @(negedge clk);
    wr_addr = a; wr_data = d; hv_ok = hv; busy = bz; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; hv_ok = 1'b1; busy = 1'b0;
    if (hv && !bz) model_step(a, d, ep, eb, ec);
    chk(prog_start == ep, "R7 prog_start", 32'(prog_start), 32'(ep));
    chk(blk_erase_start == eb, "R8 blk_erase_start", 32'(blk_erase_start), 32'(eb));
    chk(chip_erase_start == ec, "R9 chip_erase_start", 32'(chip_erase_start), 32'(ec));
    chk(in_sig_mode == m_sig, "R5 in_sig_mode", 32'(in_sig_mode), 32'(m_sig));
    if (ep) begin
      chk(cmd_addr == a, "R7 cmd_addr", 32'(cmd_addr), 32'(a));
      chk(cmd_data == d, "R7 cmd_data", 32'(cmd_data), 32'(d));
    end
    if (eb) chk(blk_idx == a[21:16], "R8 blk_idx", 32'(blk_idx), 32'(a[21:16]));
  endtask

  task automatic unlock();
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
  endtask

  task automatic chk_id(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_addr = sel;
    @(negedge clk);
    @(negedge clk);
    chk(id_word == exp, tag, 32'(id_word), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!prog_start && !blk_erase_start && !chip_erase_start, "R1 starts idle", 32'({prog_start, blk_erase_start, chip_erase_start}), 0);
    chk(!in_sig_mode, "R1 read mode", 32'(in_sig_mode), 0);
    chk(id_word == 16'h0, "R1 id_word", 32'(id_word), 0);

    // R2 R3 R7: program with junk in upper bits of key cycles
    wr(22'h3A5D55, 16'hC3AA);
    wr(22'h1232AA, 16'h7755);
    wr(22'h2FF555, 16'h12A0);
    wr(22'h2ABCDE, 16'hBEEF);

    // R8 block erase, R9 chip erase
    unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h2F1234, 16'h0030);
    unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h000555, 16'h0010);
    // R9: chip code at wrong address gives nothing
    unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h000556, 16'h0010);

    // R10 broken unlock: later program cycles start nothing
    wr(22'h000555, 16'h00AA); wr(22'h0002AB, 16'h0055);
    wr(22'h000555, 16'h00A0); wr(22'h001000, 16'h5A5A);

    // R4 single F0 mid-sequence clears the position
    wr(22'h000555, 16'h00AA); wr(22'h1F0123, 16'h00F0);
    wr(22'h0002AA, 16'h0055); wr(22'h000555, 16'h00A0); wr(22'h000100, 16'h1111);

    // R11 gated write mid-sequence keeps the position
    wr(22'h000555, 16'h00AA);
    wr(22'h000000, 16'h0000, 0, 0);
    wr(22'h0002AA, 16'h0055);
    wr(22'h000555, 16'h00A0, 0, 0);
    wr(22'h000555, 16'h00A0);
    wr(22'h0F00F0, 16'h00F0);  // R4 note: program data cycle, F0 is data

    // R5 R6 signature mode
    unlock(); wr(22'h000555, 16'h0090);
    chk_id(2'b00, 16'h0020, "R6 manufacturer code");
    chk_id(2'b01, DEV, "R6 device code");
    chk_id(2'b10, 16'h0000, "R6 other select");
    unlock(); wr(22'h000555, 16'h00A0); wr(22'h000200, 16'h2222);  // R5 ignored
    unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h000555, 16'h0010);  // R5 ignored
    wr(22'h000000, 16'h00F0, 1, 1);   // R12 busy reset ignored
    wr(22'h000000, 16'h00F0, 0, 0);   // R11 gated reset ignored
    chk(in_sig_mode == 1'b1, "R12 still signature", 32'(in_sig_mode), 1);
    unlock(); wr(22'h000555, 16'h00F0);   // R4 long reset
    chk_id(2'b00, 16'h0000, "R6 id zero in read mode");

    // R12 busy during final cycle starts nothing, position kept
    unlock(); wr(22'h000555, 16'h00A0); wr(22'h000300, 16'h3333, 1, 1);
    wr(22'h000301, 16'h3334);

    // Random stream biased toward valid next cycles
    for (int i = 0; i < 4000; i++) begin
      logic [21:0] a;
      logic [15:0] d;
      bit hv, bz;
      a = 22'($urandom);
      d = 16'($urandom);
      hv = ($urandom % 12) != 0;
      bz = ($urandom % 15) == 0;
      if (($urandom % 4) != 0) begin
        case (m_st)
          0, 4: begin a[10:0] = 11'h555; d[7:0] = 8'hAA; end
          1, 5: begin a[10:0] = 11'h2AA; d[7:0] = 8'h55; end
          2: begin
            a[10:0] = 11'h555;
            case ($urandom % 4)
              0: d[7:0] = 8'h90;
              1: d[7:0] = 8'hA0;
              2: d[7:0] = 8'h80;
              default: d[7:0] = 8'hF0;
            endcase
          end
          6: begin
            if ($urandom % 2) d[7:0] = 8'h30;
            else begin a[10:0] = 11'h555; d[7:0] = 8'h10; end
          end
          default: ;
        endcase
      end else if (($urandom % 3) == 0) begin
        d[7:0] = 8'hF0;
      end
      wr(a, d, hv, bz);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule